// File: doc/BRIEF.md
# Display List Fetch Sequencer

This block walks a display list kept in a shared byte-wide video RAM and hands each fetched word to a vector drawing engine. A symbol pointer steps through fixed-size symbol records. A line pointer, loaded from inside each symbol record, steps through the four-word line records that belong to that symbol. Every fetched word is announced by one active-low load strobe, so the destination register for that word captures the memory read data in that cycle. After the last line word of a line record, the block issues a one-cycle draw start pulse. It then waits for the engine's completion handshake before it continues.

A periodic refresh tick restarts the list from address zero, so the whole picture is redrawn at the tick rate. The same restart happens once when reset is released. A tick that arrives while the list is being walked is remembered and takes effect when the current line has been drawn. The host CPU shares the memory port. It reaches memory only while the sequencer has finished the list and is idle. At any other time a CPU request is held off with a wait signal.

Top module: `dlist_fetch_seq`

## Requirements
- R1: While reset is held, every load strobe is inactive (all ones) and draw_start is low. After reset is released, the first sequencer read is at address 0 and needs no tick.
- R2: Each symbol-record word takes two cycles. In the first cycle mem_addr carries the word address with mem_rd high. In the next cycle the load strobe whose index equals the word offset is low, and the read data is valid. A displayed symbol at base B is read at B..B+9 in order.
- R3: Record words 1 and 2 are the low and high bytes of the line pointer. Line words are read from consecutive addresses starting at that pointer, with load strobes 10..13. Bit 7 of line word 0 marks the last line of the symbol.
- R4: When bit 0 of symbol word 0 is 0, the symbol is hidden. Only word 0 is read, and the next record read is at base+10. If bit 7 of that word is also 1, the sequencer goes idle.
- R5: At no time is more than one load strobe low.
- R6: The cycle after the strobe for line word 3 (two cycles after its address) has strobe 14 low and draw_start high. draw_start is high for that single cycle, and nothing is fetched until draw_done is seen.
- R7: After draw_done, if the line was not the last, the next line is read at the address that follows the previous line record. Otherwise the next symbol is read at base+10, unless bit 7 of symbol word 0 (last symbol) is 1, in which case the sequencer goes idle.
- R8: A refresh_tick while idle restarts the list at address 0.
- R9: A refresh_tick while the list is being walked is held. When the next draw_done arrives, the list restarts at address 0 and the rest of the current pass is dropped.
- R10: While idle, mem_addr equals cpu_addr, mem_rd and mem_wr follow cpu_rd and cpu_wr, and cpu_wait is low. While the sequencer is busy, mem_wr stays low and cpu_wait is high whenever a CPU request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_tick | input | 1 | One-cycle restart request |
| cpu_rd | input | 1 | Host read request |
| cpu_wr | input | 1 | Host write request |
| cpu_addr | input | 16 | Host address |
| cpu_wdata | input | 8 | Host write data |
| cpu_wait | output | 1 | Host request is stalled |
| mem_addr | output | 16 | Video RAM address |
| mem_rd | output | 1 | Video RAM read strobe |
| mem_wr | output | 1 | Video RAM write strobe |
| mem_wdata | output | 8 | Video RAM write data |
| mem_rdata | input | 8 | Video RAM read data, one cycle after mem_rd |
| ld_n | output | 15 | One-hot active-low word load strobes |
| draw_start | output | 1 | Starts one line on the drawing engine |
| draw_done | input | 1 | Engine has finished the line |

## Verification
The bench builds the block with its default parameters: 8-bit words and 16-bit addresses, ten-word symbol records and a fifteen-step strobe cycle. That leaves four line words per record. The line pointers it uses have non-zero high bytes, so the high-byte load is visible in the read addresses. Its list holds a symbol with two lines, a hidden symbol and a last symbol. The host then rewrites that list between passes, which brings the case of a hidden last symbol within reach. A second tick is placed in the middle of a symbol fetch so that the held restart is seen taking effect after the first line.

// File: rtl/dlfs_pkg.sv
package dlfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_LAUNCH,
    ST_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    SRC_CPU,
    SRC_SYM,
    SRC_LINE
  } addr_src_t;

  // flag positions inside record words
  localparam int SHOW_BIT = 0;
  localparam int LAST_BIT = 7;
endpackage

// File: rtl/dlfs_ctrl.sv
module dlfs_ctrl
  import dlfs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REC_WORDS = 10,
  parameter int SEQ_STEPS = 15,
  localparam int SW       = $clog2(SEQ_STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rdata,
  input  logic              tick,
  input  logic              done,
  output logic [SW-1:0]     step,
  output addr_src_t         src,
  output logic              busy,
  output logic              rd_phase,
  output logic              fetch,
  output logic              launch,
  output logic              pc_reset,
  output logic              skip_add,
  output logic              pcc,
  output logic              vce,
  output logic              va_lo_ld,
  output logic              va_hi_ld
);
  localparam logic [SW-1:0] STEP_LINE0 = SW'(REC_WORDS);
  localparam logic [SW-1:0] STEP_PRE   = SW'(SEQ_STEPS - 2);
  localparam logic [SW-1:0] STEP_ONE   = SW'(1);
  localparam logic [SW-1:0] STEP_TWO   = SW'(2);

  seq_state_t    state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic          last_sym_q, last_vec_q, pend_q;
  logic          in_sym;

  assign in_sym = (step_q < STEP_LINE0);
  assign step   = step_q;
  assign busy   = (state_q != ST_IDLE);

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    src      = SRC_SYM;
    rd_phase = 1'b0;
    fetch    = 1'b0;
    launch   = 1'b0;
    pc_reset = 1'b0;
    skip_add = 1'b0;
    pcc      = 1'b0;
    vce      = 1'b0;
    va_lo_ld = 1'b0;
    va_hi_ld = 1'b0;
    case (state_q)
      ST_IDLE: begin
        src = SRC_CPU;
        if (tick || pend_q) begin
          pc_reset = 1'b1;
          step_d   = '0;
          state_d  = ST_ADDR;
        end
      end
      ST_ADDR: begin
        rd_phase = 1'b1;
        src      = in_sym ? SRC_SYM : SRC_LINE;
        state_d  = ST_DATA;
      end
      ST_DATA: begin
        fetch = 1'b1;
        if (in_sym) begin
          if (step_q == '0 && !rdata[SHOW_BIT]) begin
            skip_add = 1'b1;
            step_d   = '0;
            state_d  = rdata[LAST_BIT] ? ST_IDLE : ST_ADDR;
          end else begin
            pcc      = 1'b1;
            va_lo_ld = (step_q == STEP_ONE);
            va_hi_ld = (step_q == STEP_TWO);
            step_d   = step_q + 1'b1;
            state_d  = ST_ADDR;
          end
        end else begin
          vce     = 1'b1;
          step_d  = step_q + 1'b1;
          state_d = (step_q == STEP_PRE) ? ST_LAUNCH : ST_ADDR;
        end
      end
      ST_LAUNCH: begin
        launch  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (done) begin
          if (tick || pend_q) begin
            pc_reset = 1'b1;
            step_d   = '0;
            state_d  = ST_ADDR;
          end else if (!last_vec_q) begin
            step_d  = STEP_LINE0;
            state_d = ST_ADDR;
          end else if (last_sym_q) begin
            state_d = ST_IDLE;
          end else begin
            step_d  = '0;
            state_d = ST_ADDR;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_ADDR;
      step_q     <= '0;
      last_sym_q <= 1'b0;
      last_vec_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (fetch && step_q == '0)       last_sym_q <= rdata[LAST_BIT];
      if (fetch && step_q == STEP_LINE0) last_vec_q <= rdata[LAST_BIT];
      if (pc_reset)  pend_q <= 1'b0;
      else if (tick) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dlfs_counters.sv
module dlfs_counters #(
  parameter int DATA_W    = 8,
  parameter int REC_WORDS = 10,
  localparam int ADDR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rdata,
  input  logic              pc_reset,
  input  logic              skip_add,
  input  logic              pcc,
  input  logic              vce,
  input  logic              va_lo_ld,
  input  logic              va_hi_ld,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] va
);
  function automatic logic [ADDR_W-1:0] next_record(input logic [ADDR_W-1:0] base);
    return base + ADDR_W'(REC_WORDS);
  endfunction

  function automatic logic [ADDR_W-1:0] next_word(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      va <= '0;
    end else begin
      if (pc_reset)      pc <= '0;
      else if (skip_add) pc <= next_record(pc);
      else if (pcc)      pc <= next_word(pc);

      if (va_lo_ld)      va <= {va[ADDR_W-1:DATA_W], rdata};
      else if (va_hi_ld) va <= {rdata, va[DATA_W-1:0]};
      else if (vce)      va <= next_word(va);
    end
  end
endmodule

// File: rtl/dlfs_strobes.sv
module dlfs_strobes #(
  parameter int SEQ_STEPS = 15,
  localparam int SW       = $clog2(SEQ_STEPS)
) (
  input  logic                 fetch,
  input  logic                 launch,
  input  logic [SW-1:0]        step,
  output logic [SEQ_STEPS-1:0] ld_n
);
  for (genvar i = 0; i < SEQ_STEPS; i++) begin : g_strb
    if (i == SEQ_STEPS - 1) begin : g_launch
      assign ld_n[i] = !launch;
    end else begin : g_word
      assign ld_n[i] = !(fetch && step == SW'(i));
    end
  end
endmodule

// File: rtl/dlist_fetch_seq.sv
module dlist_fetch_seq
  import dlfs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REC_WORDS = 10,
  parameter int SEQ_STEPS = 15,
  localparam int ADDR_W   = 2 * DATA_W,
  localparam int SW       = $clog2(SEQ_STEPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 refresh_tick,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic                 cpu_wait,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [SEQ_STEPS-1:0] ld_n,
  output logic                 draw_start,
  input  logic                 draw_done
);
  logic [SW-1:0]     step;
  addr_src_t         src;
  logic              busy, rd_phase, fetch, launch;
  logic              pc_reset, skip_add, pcc, vce, va_lo_ld, va_hi_ld;
  logic [ADDR_W-1:0] pc_q, va_q;

  dlfs_ctrl #(.DATA_W(DATA_W), .REC_WORDS(REC_WORDS), .SEQ_STEPS(SEQ_STEPS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rdata(mem_rdata), .tick(refresh_tick), .done(draw_done),
    .step(step), .src(src), .busy(busy), .rd_phase(rd_phase), .fetch(fetch),
    .launch(launch), .pc_reset(pc_reset), .skip_add(skip_add), .pcc(pcc), .vce(vce),
    .va_lo_ld(va_lo_ld), .va_hi_ld(va_hi_ld)
  );

  dlfs_counters #(.DATA_W(DATA_W), .REC_WORDS(REC_WORDS)) cnt_i (
    .clk(clk), .rst_n(rst_n), .rdata(mem_rdata), .pc_reset(pc_reset),
    .skip_add(skip_add), .pcc(pcc), .vce(vce), .va_lo_ld(va_lo_ld),
    .va_hi_ld(va_hi_ld), .pc(pc_q), .va(va_q)
  );

  dlfs_strobes #(.SEQ_STEPS(SEQ_STEPS)) strb_i (
    .fetch(fetch), .launch(launch), .step(step), .ld_n(ld_n)
  );

  always_comb begin
    case (src)
      SRC_SYM:  mem_addr = pc_q;
      SRC_LINE: mem_addr = va_q;
      default:  mem_addr = cpu_addr;
    endcase
  end

  assign mem_rd     = busy ? rd_phase : cpu_rd;
  assign mem_wr     = !busy && cpu_wr;
  assign mem_wdata  = cpu_wdata;
  assign cpu_wait   = busy && (cpu_rd || cpu_wr);
  assign draw_start = launch;
endmodule

// File: rtl/dlist_fetch_seq_chk.sv
module dlist_fetch_seq_chk #(
  parameter int DATA_W    = 8,
  parameter int REC_WORDS = 10,
  parameter int SEQ_STEPS = 15,
  localparam int ADDR_W   = 2 * DATA_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [SEQ_STEPS-1:0] ld_n,
  input logic                 draw_start,
  input logic                 busy,
  input logic                 cpu_rd,
  input logic                 cpu_wr,
  input logic                 cpu_wait,
  input logic                 mem_wr,
  input logic                 pc_reset,
  input logic                 skip_add,
  input logic                 pcc,
  input logic                 vce,
  input logic [ADDR_W-1:0]    pc_q,
  input logic [ADDR_W-1:0]    va_q
);
  a_r1_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pc_reset |=> (pc_q == '0));

  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    vce |=> (va_q == $past(va_q) + ADDR_W'(1)));

  a_r4_skip_record: assert property (@(posedge clk) disable iff (!rst_n)
    skip_add |=> (pc_q == $past(pc_q) + ADDR_W'(REC_WORDS)));

  a_r4_skip_not_step: assert property (@(posedge clk) disable iff (!rst_n)
    skip_add |-> !pcc);

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ld_n));

  a_r6_launch_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    draw_start |-> !ld_n[SEQ_STEPS-1]);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    draw_start |=> (!draw_start && busy));

  a_r10_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_wr);

  a_r10_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cpu_rd || cpu_wr)) |-> cpu_wait);
endmodule

bind dlist_fetch_seq dlist_fetch_seq_chk #(
  .DATA_W(DATA_W), .REC_WORDS(REC_WORDS), .SEQ_STEPS(SEQ_STEPS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .draw_start(draw_start), .busy(busy),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wait(cpu_wait), .mem_wr(mem_wr),
  .pc_reset(pc_reset), .skip_add(skip_add), .pcc(pcc), .vce(vce),
  .pc_q(pc_q), .va_q(va_q)
);

// File: tb/dlist_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module dlist_fetch_seq_tb_top;
  localparam int DW    = 8;
  localparam int AW    = 16;
  localparam int REC   = 10;
  localparam int STEPS = 15;
  localparam int LINEW = STEPS - 1 - REC;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            refresh_tick = 1'b0;
  logic            cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [AW-1:0]   cpu_addr = '0;
  logic [DW-1:0]   cpu_wdata = '0;
  logic            cpu_wait;
  logic [AW-1:0]   mem_addr;
  logic            mem_rd, mem_wr;
  logic [DW-1:0]   mem_wdata;
  logic [DW-1:0]   mem_rdata = '0;
  logic [STEPS-1:0] ld_n;
  logic            draw_start;
  logic            draw_done = 1'b0;

  always #10 clk = ~clk;

  dlist_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ld_n(ld_n), .draw_start(draw_start), .draw_done(draw_done)
  );

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  logic [7:0] mem [int];

  function automatic logic [7:0] m(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= m(int'(mem_addr));
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
  end

  typedef struct {
    int    kind;
    int    val;
    string tag;
  } item_t;
  item_t exp_q[$];

  task automatic push(input int kind, input int val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected traffic of one pass, computed from the record rules
  task automatic walk(input int max_draws, input string first_tag);
    int pc = 0;
    int draws = 0;
    string t = first_tag;
    for (int s = 0; s < 64; s++) begin
      logic [7:0] w0;
      int va;
      string vt;
      bit lastv;
      w0 = m(pc);
      push(0, pc, t);
      push(1, 0, "R2");
      if (!w0[0]) begin
        pc = (pc + REC) & 16'hFFFF;
        t = "R4";
        if (w0[7]) return;
        continue;
      end
      for (int k = 1; k < REC; k++) begin
        push(0, pc + k, "R2");
        push(1, k, "R2");
      end
      va = {m(pc + 2), m(pc + 1)};
      vt = "R3";
      for (int v = 0; v < 16; v++) begin
        lastv = m(va)[7];
        for (int k = 0; k < LINEW; k++) begin
          push(0, (va + k) & 16'hFFFF, (k == 0) ? vt : "R3");
          push(1, REC + k, "R3");
        end
        va = (va + LINEW) & 16'hFFFF;
        push(1, STEPS - 1, "R6");
        push(2, 0, "R6");
        draws++;
        if (draws == max_draws) return;
        if (lastv) break;
        vt = "R7";
      end
      pc = (pc + REC) & 16'hFFFF;
      t = "R7";
      if (w0[7]) return;
    end
  endtask

  task automatic take(input int kind, input int val);
    item_t it;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2", kind * 65536 + val, -1, "unexpected event");
      return;
    end
    it = exp_q.pop_front();
    check(it.kind == kind && it.val == val, it.tag, kind * 65536 + val,
          it.kind * 65536 + it.val, "event");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (mem_rd) take(0, int'(mem_addr));
      if (ld_n != '1) begin
        int idx = 0;
        if ($countones(~ld_n) > 1)
          check(1'b0, "R5", $countones(~ld_n), 1, "strobes low");
        for (int i = 0; i < STEPS; i++) if (!ld_n[i]) idx = i;
        take(1, idx);
      end
      if (draw_start) take(2, 0);
    end
  end

  // drawing engine model
  initial begin
    forever begin
      @(negedge clk);
      if (draw_start) begin
        repeat (3) @(negedge clk);
        draw_done = 1'b1;
        @(negedge clk);
        draw_done = 1'b0;
      end
    end
  end

  task automatic pulse_tick();
    @(negedge clk);
    refresh_tick = 1'b1;
    @(negedge clk);
    refresh_tick = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0, "items left");
    check(ld_n == '1 && !draw_start && !mem_rd, tag, int'(ld_n), 32'h7FFF, "idle outputs");
  endtask

  task automatic cpu_write(input int a, input int d);
    @(negedge clk);
    cpu_addr = AW'(a); cpu_wdata = DW'(d); cpu_wr = 1'b1;
    #2;
    check(!cpu_wait && mem_wr && mem_addr == AW'(a), "R10", int'(mem_addr), a, "idle write");
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  initial begin
    // list: symbol 0 with two lines, hidden symbol 1, last symbol 2
    for (int k = 0; k < REC; k++) begin
      mem[k] = 8'(8'h10 + k); mem[10 + k] = 8'(8'h30 + k); mem[20 + k] = 8'(8'h50 + k);
    end
    mem[0] = 8'h01; mem[1] = 8'h00; mem[2] = 8'h01;
    mem[10] = 8'h00; mem[11] = 8'h80; mem[12] = 8'h02;
    mem[20] = 8'h81; mem[21] = 8'h00; mem[22] = 8'h02;
    mem[16'h0100] = 8'h00; mem[16'h0104] = 8'h80;
    mem[16'h0200] = 8'h80; mem[16'h0280] = 8'h80;

    walk(-1, "R1");
    mon_en = 1'b1;
    repeat (3) @(negedge clk);
    check(ld_n == '1 && !draw_start, "R1", int'(ld_n), 32'h7FFF, "reset outputs");
    rst_n = 1'b1;

    // host request while busy must stall
    @(posedge draw_start);
    @(negedge clk);
    cpu_addr = 16'h0000; cpu_wdata = 8'hFF; cpu_wr = 1'b1;
    #2;
    check(cpu_wait && !mem_wr, "R10", {cpu_wait, mem_wr}, 2, "busy stall");
    @(negedge clk);
    cpu_wr = 1'b0;
    drain("R7");
    check(m(0) == 8'h01, "R10", m(0), 1, "stalled write kept out");

    // host access while idle
    mon_en = 1'b0;
    cpu_write(16'h0300, 8'h5A);
    @(negedge clk);
    cpu_addr = 16'h0300; cpu_rd = 1'b1;
    #2;
    check(mem_rd && !cpu_wait && mem_addr == 16'h0300, "R10", int'(mem_addr), 16'h0300, "idle read");
    @(negedge clk);
    cpu_rd = 1'b0;
    check(mem_rdata == 8'h5A, "R10", mem_rdata, 8'h5A, "idle read data");
    cpu_write(10, 8'h01);   // symbol 1 now shown
    cpu_write(20, 8'h80);   // symbol 2 hidden and last
    repeat (5) @(negedge clk);
    check(!mem_rd && ld_n == '1, "R8", int'(mem_rd), 0, "stays idle without tick");

    // restart from idle
    mon_en = 1'b1;
    walk(-1, "R8");
    pulse_tick();
    drain("R4");

    // tick during the walk is held until the first line is done
    walk(1, "R8");
    walk(-1, "R9");
    pulse_tick();
    repeat (6) @(negedge clk);
    pulse_tick();
    drain("R9");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule